// File: doc/BRIEF.md
# Debug Register Target with Return-to-Zero Handshake

This block is the target end of a small debug register bus. A master starts an access by raising a request strobe. In the same cycle it presents an address, write data and a write flag. The target answers by raising an acknowledge. It keeps acknowledge high, with its read data frozen, until it has seen the request fall. Acknowledge then drops, and the target waits for the request to be low before it will take another access. Each rising request is therefore one full four-phase transaction.

Behind the handshake there is a small register bank. Address 0 is a read-only identification word. The remaining in-range addresses are scratch registers that can be read and written. Any address outside the bank is still acknowledged: a read from it returns zero and a write to it has no effect. A parameter inserts a fixed number of wait cycles, from 0 to 15, between sampling the request and raising acknowledge. The block has one clock and a synchronous active-high reset.

Top module: `dbg_reg_target`

## Requirements
- R1: While reset is high, and on the cycle after it, acknowledge is low and the read data is zero. Every scratch register reads back as zero after reset, including after a reset applied in the middle of a transaction.
- R2: With `WAIT_CYCLES` = 0, acknowledge is high on the first clock edge after the edge that samples the request high from idle.
- R3: With `WAIT_CYCLES` = W (0 to 15), acknowledge first goes high W+1 clock edges after the edge that samples the request high from idle.
- R4: Acknowledge stays high on every edge at which the request is still sampled high.
- R5: Acknowledge goes low on the first edge at which the request is sampled low while acknowledge is high.
- R6: Read data keeps the same value on every cycle in which acknowledge stays high.
- R7: A write changes the addressed register exactly once, using the address and data present when the request rose. Changes to the address or write data while the request is held have no effect.
- R8: Once acknowledge has fallen, it does not rise again until the request has been low and then rises again.
- R9: Address 0 reads as the constant `ID_VALUE` (default 32'h5A170C3E). Writes to address 0 are ignored.
- R10: Addresses 1 to `NUM_REGS`-1 are read/write scratch registers that hold the last value written to them.
- R11: An access to any address at or above `NUM_REGS` is acknowledged with the normal timing. A read from it returns zero, and a write to it changes no register. This holds even when the low address bits match a mapped register.
- R12: During a write transaction the read data shows zero while acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Transaction request strobe from the master |
| addr_i | input | ADDR_W | Register address, valid when the request rises |
| wdata_i | input | DATA_W | Write data, valid when the request rises |
| wr_i | input | 1 | 1 = write, 0 = read, valid when the request rises |
| ack_o | output | 1 | Acknowledge; held high until the request is seen low |
| rdata_o | output | DATA_W | Read data; stable while acknowledge is high |

## Verification
The bench builds two copies of the block side by side. Both use the default 8-bit address, 32-bit data and eight-register bank. One copy has `WAIT_CYCLES` = 0 and the other has `WAIT_CYCLES` = 3. The zero-wait copy covers the direct idle-to-acknowledge path, in which the command is taken from the live inputs. The three-wait copy covers the wait-counter path, in which the command comes from the latched copy, and shows that the latency scales with the parameter. Addresses 8, 9, 0x88 and 0xFF exercise the unmapped range, including aliasing of the low address bits onto mapped registers.

// File: rtl/dbg_tgt_pkg.sv
package dbg_tgt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_ACK  = 2'd2,
      ST_DONE = 2'd3
   } tgt_state_e;

   localparam int unsigned MAX_WAIT = 15;
   localparam int unsigned WAIT_CNT_W = 4;

endpackage

// File: rtl/dbg_tgt_fsm.sv
module dbg_tgt_fsm
   import dbg_tgt_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned WAIT_CYCLES = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              wr_i,
   output logic              ack_o,
   output logic              enter_ack_o,
   output logic [ADDR_W-1:0] cmd_addr_o,
   output logic [DATA_W-1:0] cmd_wdata_o,
   output logic              cmd_wr_o
);

   localparam int unsigned CNT_W = WAIT_CNT_W;

   tgt_state_e        state_q, state_d;
   logic              wait_done;
   logic [ADDR_W-1:0] lat_addr_q;
   logic [DATA_W-1:0] lat_wdata_q;
   logic              lat_wr_q;
   logic              start;

   assign start = (state_q == ST_IDLE) && req_i;

   // Command capture on the rising request
   always_ff @(posedge clk) begin
      if (rst) begin
         lat_addr_q  <= '0;
         lat_wdata_q <= '0;
         lat_wr_q    <= 1'b0;
      end else if (start) begin
         lat_addr_q  <= addr_i;
         lat_wdata_q <= wdata_i;
         lat_wr_q    <= wr_i;
      end
   end

   // In idle the command comes straight from the bus, later from the latch
   always_comb begin
      if (state_q == ST_IDLE) begin
         cmd_addr_o  = addr_i;
         cmd_wdata_o = wdata_i;
         cmd_wr_o    = wr_i;
      end else begin
         cmd_addr_o  = lat_addr_q;
         cmd_wdata_o = lat_wdata_q;
         cmd_wr_o    = lat_wr_q;
      end
   end

   // Wait-state counter variant chosen by parameter
   generate
      if (WAIT_CYCLES == 0) begin : g_nowait
         assign wait_done = 1'b1;
      end else begin : g_wait
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
            end else if (start) begin
               cnt_q <= CNT_W'(WAIT_CYCLES - 1);
            end else if (state_q == ST_WAIT && cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign wait_done = (cnt_q == '0);

         a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
            (state_q == ST_WAIT) |-> (cnt_q < CNT_W'(WAIT_CYCLES)))
            else $error("wait counter out of range");

         a_r3_start_waits: assert property (@(posedge clk) disable iff (rst)
            start |=> !ack_o)
            else $error("acknowledge skipped wait states");
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (req_i) state_d = (WAIT_CYCLES == 0) ? ST_ACK : ST_WAIT;
         ST_WAIT: if (wait_done) state_d = ST_ACK;
         ST_ACK:  if (!req_i) state_d = ST_DONE;
         ST_DONE: if (!req_i) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign ack_o       = (state_q == ST_ACK);
   assign enter_ack_o = (state_q != ST_ACK) && (state_d == ST_ACK);

   // Assertions guarding the handshake
   a_r4_ack_held: assert property (@(posedge clk) disable iff (rst)
      (ack_o && req_i) |=> ack_o)
      else $error("acknowledge dropped while request high");

   a_r5_ack_falls: assert property (@(posedge clk) disable iff (rst)
      (ack_o && !req_i) |=> !ack_o)
      else $error("acknowledge held after request low");

   a_r8_no_reack: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_DONE) |=> !ack_o)
      else $error("acknowledge rose without a new request");

   generate
      if (WAIT_CYCLES == 0) begin : g_chk_zero
         a_r2_zero_wait: assert property (@(posedge clk) disable iff (rst)
            start |=> ack_o)
            else $error("zero-wait acknowledge late");
      end
   endgenerate

endmodule

// File: rtl/dbg_tgt_regbank.sv
module dbg_tgt_regbank #(
   parameter int unsigned    ADDR_W   = 8,
   parameter int unsigned    DATA_W   = 32,
   parameter int unsigned    NUM_REGS = 8,
   parameter logic [DATA_W-1:0] ID_VALUE = 32'h5A17_0C3E
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int unsigned SEL_W = $clog2(NUM_REGS);

   logic [DATA_W-1:0] bank [NUM_REGS];
   logic              in_range;
   logic [SEL_W-1:0]  sel;

   assign in_range = (int'(addr_i) < int'(NUM_REGS));
   assign sel      = addr_i[SEL_W-1:0];

   // Slot 0 is the fixed identification word
   assign bank[0] = ID_VALUE;

   generate
      for (genvar i = 1; i < NUM_REGS; i++) begin : g_scratch
         logic hit;
         assign hit = wr_en_i && in_range && (sel == SEL_W'(i));
         always_ff @(posedge clk) begin
            if (rst)      bank[i] <= '0;
            else if (hit) bank[i] <= wdata_i;
         end
      end
   endgenerate

   assign rdata_o = in_range ? bank[sel] : '0;

   a_r7_single_write: assert property (@(posedge clk) disable iff (rst)
      wr_en_i |=> !wr_en_i)
      else $error("write strobe repeated");

   a_r9_id_fixed: assert property (@(posedge clk) disable iff (rst)
      (addr_i == '0) |-> (rdata_o == ID_VALUE))
      else $error("identification word corrupted");

endmodule

// File: rtl/dbg_tgt_rdhold.sv
module dbg_tgt_rdhold #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic              is_read_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [DATA_W-1:0] hold_o
);

   always_ff @(posedge clk) begin
      if (rst)         hold_o <= '0;
      else if (load_i) hold_o <= is_read_i ? rdata_i : '0;
   end

   a_r6_hold_steady: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(hold_o))
      else $error("held read data changed without a load");

endmodule

// File: rtl/dbg_reg_target.sv
module dbg_reg_target
   import dbg_tgt_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 8,
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       NUM_REGS    = 8,
   parameter int unsigned       WAIT_CYCLES = 0,
   parameter logic [DATA_W-1:0] ID_VALUE    = 32'h5A17_0C3E
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              wr_i,
   output logic              ack_o,
   output logic [DATA_W-1:0] rdata_o
);

   // Elaboration-time parameter checks
   generate
      if (WAIT_CYCLES > MAX_WAIT) begin : g_bad_wait
         $error("WAIT_CYCLES must be 0..15");
      end
      if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
         $error("NUM_REGS must be a power of two, at least 2");
      end
      if (ADDR_W > 31 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_addr
         $error("address width cannot cover the register bank");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic              enter_ack;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_wdata;
   logic              cmd_wr;
   logic [DATA_W-1:0] bank_rdata;

   dbg_tgt_fsm #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .WAIT_CYCLES (WAIT_CYCLES)
   ) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .req_i       (req_i),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .wr_i        (wr_i),
      .ack_o       (ack_o),
      .enter_ack_o (enter_ack),
      .cmd_addr_o  (cmd_addr),
      .cmd_wdata_o (cmd_wdata),
      .cmd_wr_o    (cmd_wr)
   );

   dbg_tgt_regbank #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .ID_VALUE (ID_VALUE)
   ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en_i (enter_ack && cmd_wr),
      .addr_i  (cmd_addr),
      .wdata_i (cmd_wdata),
      .rdata_o (bank_rdata)
   );

   dbg_tgt_rdhold #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk       (clk),
      .rst       (rst),
      .load_i    (enter_ack),
      .is_read_i (!cmd_wr),
      .rdata_i   (bank_rdata),
      .hold_o    (rdata_o)
   );

   a_r6_rdata_stable: assert property (@(posedge clk) disable iff (rst)
      ack_o |=> (!ack_o || $stable(rdata_o)))
      else $error("read data moved during acknowledge");

   a_r1_post_reset: assert property (@(posedge clk)
      rst |=> (!ack_o && rdata_o == '0))
      else $error("reset state wrong");

endmodule

// File: tb/test_dbg_reg_target.sv
`timescale 1ns/1ps
module test_dbg_reg_target;

   localparam logic [31:0] ID = 32'h5A17_0C3E;
   localparam int W0 = 0;
   localparam int W1 = 3;

   typedef struct packed {
      logic        sel;
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] wd;
      logic [31:0] exp;
      logic [7:0]  req_n;
   } vec_t;

   localparam int NV = 18;
   // Requirements exercised by the table: R3 R9 R10 R11 R12
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 8'h00, 32'h0000_0000, ID,            8'd9},
      '{1'b0, 1'b0, 8'h02, 32'h0000_0000, 32'h0,         8'd10},
      '{1'b0, 1'b1, 8'h01, 32'h1234_5678, 32'h0,         8'd12},
      '{1'b0, 1'b0, 8'h01, 32'h0000_0000, 32'h1234_5678, 8'd10},
      '{1'b0, 1'b1, 8'h07, 32'hCAFE_F00D, 32'h0,         8'd12},
      '{1'b0, 1'b0, 8'h07, 32'h0000_0000, 32'hCAFE_F00D, 8'd10},
      '{1'b0, 1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0,         8'd9},
      '{1'b0, 1'b0, 8'h00, 32'h0000_0000, ID,            8'd9},
      '{1'b0, 1'b1, 8'h08, 32'h1111_1111, 32'h0,         8'd11},
      '{1'b0, 1'b0, 8'h08, 32'h0000_0000, 32'h0,         8'd11},
      '{1'b0, 1'b0, 8'h00, 32'h0000_0000, ID,            8'd11},
      '{1'b0, 1'b1, 8'h09, 32'h0000_0000, 32'h0,         8'd11},
      '{1'b0, 1'b0, 8'h01, 32'h0000_0000, 32'h1234_5678, 8'd11},
      '{1'b0, 1'b0, 8'hFF, 32'h0000_0000, 32'h0,         8'd11},
      '{1'b1, 1'b1, 8'h05, 32'h0BAD_BEEF, 32'h0,         8'd3},
      '{1'b1, 1'b0, 8'h05, 32'h0000_0000, 32'h0BAD_BEEF, 8'd3},
      '{1'b1, 1'b0, 8'h00, 32'h0000_0000, ID,            8'd9},
      '{1'b1, 1'b0, 8'h88, 32'h0000_0000, 32'h0,         8'd11}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req   [2];
   logic [7:0]  addr  [2];
   logic [31:0] wdata [2];
   logic        wr    [2];
   logic        ack   [2];
   logic [31:0] rdata [2];

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #4 clk = ~clk;

   dbg_reg_target #(.WAIT_CYCLES(W0)) i_dbg_reg_target (
      .clk(clk), .rst(rst), .req_i(req[0]), .addr_i(addr[0]),
      .wdata_i(wdata[0]), .wr_i(wr[0]), .ack_o(ack[0]), .rdata_o(rdata[0]));

   dbg_reg_target #(.WAIT_CYCLES(W1)) i_dbg_reg_target_w3 (
      .clk(clk), .rst(rst), .req_i(req[1]), .addr_i(addr[1]),
      .wdata_i(wdata[1]), .wr_i(wr[1]), .ack_o(ack[1]), .rdata_o(rdata[1]));

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic xact(input int s, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic [31:0] exp,
                       input int hold, input bit scramble, input string tag);
      int lat;
      logic [31:0] first;
      @(negedge clk);
      req[s] = 1'b1; wr[s] = w; addr[s] = a; wdata[s] = d;
      lat = 0;
      while (1) begin
         @(negedge clk);
         lat++;
         if (ack[s] || lat > 40) break;
      end
      // R2 / R3: latency is wait cycles plus one edge
      chk(lat == ((s == 0) ? W0 : W1) + 1, (s == 0) ? "R2 latency" : "R3 latency",
          32'(lat), 32'(((s == 0) ? W0 : W1) + 1));
      chk(rdata[s] === exp, tag, rdata[s], exp);
      first = rdata[s];
      for (int h = 0; h < hold; h++) begin
         if (scramble) begin
            addr[s]  = a ^ 8'h02;
            wdata[s] = ~d;
         end
         @(negedge clk);
         chk(ack[s] === 1'b1, "R4 ack held", 32'(ack[s]), 32'd1);
         chk(rdata[s] === first, "R6 rdata stable", rdata[s], first);
      end
      req[s] = 1'b0;
      @(negedge clk);
      chk(ack[s] === 1'b0, "R5 ack falls", 32'(ack[s]), 32'd0);
      @(negedge clk);
      chk(ack[s] === 1'b0, "R8 no re-ack", 32'(ack[s]), 32'd0);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      for (int s = 0; s < 2; s++) begin
         req[s] = 1'b0; addr[s] = '0; wdata[s] = '0; wr[s] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state on both copies
      for (int s = 0; s < 2; s++) begin
         chk(ack[s] === 1'b0, "R1 ack after reset", 32'(ack[s]), 32'd0);
         chk(rdata[s] === 32'h0, "R1 rdata after reset", rdata[s], 32'h0);
      end

      // Table walk
      for (int i = 0; i < NV; i++) begin
         xact(int'(VECS[i].sel), VECS[i].wr, VECS[i].addr, VECS[i].wd, VECS[i].exp,
              i % 4, 1'b0, $sformatf("R%0d vector %0d", VECS[i].req_n, i));
      end

      // R7: inputs changed during a held write have no effect
      xact(0, 1'b1, 8'h04, 32'hA5A5_0F0F, 32'h0, 8, 1'b1, "R7 scrambled write");
      xact(0, 1'b0, 8'h04, 32'h0, 32'hA5A5_0F0F, 1, 1'b0, "R7 written once");
      xact(0, 1'b0, 8'h06, 32'h0, 32'h0, 1, 1'b0, "R7 neighbour untouched");
      xact(1, 1'b1, 8'h02, 32'h7777_0001, 32'h0, 5, 1'b1, "R7 scrambled write w3");
      xact(1, 1'b0, 8'h02, 32'h0, 32'h7777_0001, 0, 1'b0, "R7 latched write w3");
      xact(1, 1'b0, 8'h00, 32'h0, ID, 0, 1'b0, "R7 neighbour untouched w3");

      // R1: reset in the middle of an acknowledged read of a written register
      @(negedge clk);
      req[0] = 1'b1; wr[0] = 1'b0; addr[0] = 8'h07; wdata[0] = '0;
      @(negedge clk);
      chk(ack[0] === 1'b1, "R1 pre-reset ack", 32'(ack[0]), 32'd1);
      chk(rdata[0] === 32'hCAFE_F00D, "R1 pre-reset rdata", rdata[0], 32'hCAFE_F00D);
      rst = 1'b1;
      req[0] = 1'b0;
      @(negedge clk);
      chk(ack[0] === 1'b0, "R1 ack in reset", 32'(ack[0]), 32'd0);
      chk(rdata[0] === 32'h0, "R1 rdata in reset", rdata[0], 32'h0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      xact(0, 1'b0, 8'h07, 32'h0, 32'h0, 0, 1'b0, "R1 scratch cleared");
      xact(0, 1'b0, 8'h01, 32'h0, 32'h0, 0, 1'b0, "R1 scratch cleared");
      xact(1, 1'b0, 8'h05, 32'h0, 32'h0, 0, 1'b0, "R1 scratch cleared w3");
      xact(0, 1'b0, 8'h00, 32'h0, ID, 0, 1'b0, "R9 id after reset");

      finish_run();
   end

endmodule